// File: doc/BRIEF.md
# Threshold-Flagged Byte Queue

This block is a byte-wide circular queue shared between a host register port and the bus engine of a serial controller. The host pushes bytes to be sent and pops bytes that were received. The engine pushes received bytes and pops bytes to be sent. Depth is a parameter and may be 8, 16, 32 or 64 bytes. Read and write pointers are six bits wide and wrap modulo 64. A single occupancy count covers both directions.

A 16-bit configuration register holds two 6-bit thresholds: receive in bits 13:8 and transmit in bits 5:0. The block compares the occupancy, or the remaining transfer count, against these thresholds. From that comparison it raises either a "ready" flag (more than the threshold) or a "draining" flag (at or below it). It also flags host accesses made to a full or an empty queue, underflow, overrun and the host emptying the queue. A packed status word reports the depth code, the occupancy and the remaining transfer count.

The fill controller is a three-state machine:
- **EMPTY**: an accepted push moves it to PARTIAL.
- **PARTIAL**: the last pop moves it to EMPTY, and a push that reaches DEPTH moves it to FULL.
- **FULL**: a pop with no push moves it to PARTIAL.
- **flush**: from any state, a clearing config write returns it to EMPTY.

Top module: `tfifo_thresh`

## Requirements
- R1: After reset the occupancy is 0, every flag output is 0, `cfg_q` is 0 and `host_rdata` is 0.
- R2: Bytes leave in the order they entered, whoever pushed or popped them. Each accepted push adds one to the occupancy and each accepted pop removes one. An accepted push and an accepted pop in the same cycle leave the occupancy unchanged. A push into a FULL queue is accepted only when a pop is accepted in the same cycle.
- R3: When host and engine push in the same cycle, only the host byte is stored and the engine byte is dropped without a flag. When both pop in the same cycle, only the host receives the byte.
- R4: A config write stores `cfg_wdata & 16'hBFBF`. The receive threshold is bits 13:8 and the transmit threshold is bits 5:0. Thresholds take effect from the cycle after the write.
- R5: A config write with bit 14 or bit 6 set empties the queue in the next cycle and clears `rx_ready` and `rx_drain`. Any push or pop in that same cycle is ignored.
- R6: A host pop from a non-empty queue returns the head byte on `host_rdata` one cycle later, clears `acc_err` and clears `rx_ovr`. A host pop from an empty queue returns 0, sets `acc_err` and leaves the occupancy unchanged.
- R7: A host push into a full queue with no pop in that cycle discards the byte and sets `acc_err`; the occupancy stays at DEPTH. An accepted host push clears `acc_err`. Every host push clears `tx_udf`, `tx_ready` and `tx_drain`.
- R8: After an accepted engine push (with no host pop), if the occupancy exceeds the receive threshold then `rx_ready`=1 and `rx_drain`=0. Otherwise `rx_ready`=0 and `rx_drain`=1.
- R9: After an accepted host pop, the receive flags depend on the bytes left:
  - if none remain, both receive flags clear and `acc_ready` is set;
  - if 1 up to the receive threshold remain, `rx_ready`=0 and `rx_drain`=1;
  - if more remain, the receive flags are unchanged.
- R10: An engine push into a full queue with no pop in that cycle is discarded and sets `rx_ovr`.
- R11: An engine pop from an empty queue sets `tx_udf`. An engine pop that empties the queue while `xfer_left` is non-zero sets `tx_ready` if `xfer_left` exceeds the transmit threshold, and `tx_drain` otherwise.
- R12: `buf_status` is formed as follows:
  - bits 15:14 carry the depth code (8→0, 16→1, 32→2, 64→3);
  - bits 13:8 carry the occupancy modulo 64;
  - bits 7:6 are zero;
  - bits 5:0 carry `xfer_left[5:0]`.
- R13: `flag_ack` bits clear flags in the next cycle unless a setting event happens in the same cycle: bit 0 clears `acc_ready`, bit 1 clears `acc_err`, bit 2 clears `tx_udf` and bit 3 clears `rx_ovr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_we | input | 1 | config register write strobe |
| cfg_wdata | input | 16 | config write data; bit 14 or bit 6 flushes the queue |
| cfg_q | output | 16 | stored config value |
| host_push | input | 1 | host byte push |
| host_wdata | input | 8 | host push byte |
| host_pop | input | 1 | host byte pop |
| host_rdata | output | 8 | byte returned by the last host pop |
| eng_push | input | 1 | engine byte push |
| eng_wdata | input | 8 | engine push byte |
| eng_pop | input | 1 | engine byte pop |
| eng_rdata | output | 8 | head byte, valid while not empty |
| xfer_left | input | 16 | remaining transfer count |
| flag_ack | input | 4 | write-one-to-clear for the sticky flags |
| rx_ready | output | 1 | receive data above threshold |
| rx_drain | output | 1 | receive data at or below threshold |
| tx_ready | output | 1 | transmit refill above threshold |
| tx_drain | output | 1 | transmit refill at or below threshold |
| acc_ready | output | 1 | host popped the queue empty |
| acc_err | output | 1 | host access to full or empty queue |
| tx_udf | output | 1 | engine popped an empty queue |
| rx_ovr | output | 1 | engine pushed into a full queue |
| buf_status | output | 16 | packed depth code, occupancy and count |

## Verification
The hardest situations to reach are the FULL-state corners. These are the rejected host push, the dropped engine push, and a push accepted only because a pop happens in the same cycle. Reaching them needs DEPTH engine pushes in a row, with the receive flags sampled at each step across the threshold boundary. The directed sequence therefore fills the queue completely through the engine port and then attempts one more push on each side. It then drains through the host port, checking every byte and both receive flags at threshold +1, threshold and zero. A separate step pairs an engine push with a host pop to show that the occupancy holds.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;

    localparam int PTR_W = 6;
    localparam int CNT_W = PTR_W + 1;
    localparam logic [15:0] CFG_KEEP = 16'hBFBF;
    localparam int RX_CLR_BIT = 14;
    localparam int TX_CLR_BIT = 6;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_PART  = 2'd1,
        FS_FULL  = 2'd2
    } fill_state_e;

    typedef struct packed {
        logic rx_ready;
        logic rx_drain;
        logic tx_ready;
        logic tx_drain;
        logic acc_ready;
        logic acc_err;
        logic tx_udf;
        logic rx_ovr;
    } flag_t;

    function automatic logic [1:0] depth_code(input int d);
        case (d)
            8:       return 2'd0;
            16:      return 2'd1;
            32:      return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/tfifo_store.sv
module tfifo_store
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             h_push,
    input  logic [7:0]       h_wdata,
    input  logic             e_push,
    input  logic [7:0]       e_wdata,
    input  logic             h_pop,
    input  logic             e_pop,
    output logic             h_push_ok,
    output logic             h_push_rej,
    output logic             e_push_ok,
    output logic             e_push_rej,
    output logic             h_pop_ok,
    output logic             h_pop_rej,
    output logic             e_pop_ok,
    output logic             e_pop_rej,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output fill_state_e      state
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    fill_state_e      state_nxt;
    logic             any_push, any_pop, push_ok, pop_ok;
    logic [7:0]       wbyte;

    // acceptance decided by fill state
    always_comb begin
        any_push = h_push | e_push;
        any_pop  = h_pop | e_pop;
        push_ok  = 1'b0;
        pop_ok   = 1'b0;
        unique case (state)
            FS_EMPTY: begin
                push_ok = any_push;
                pop_ok  = 1'b0;
            end
            FS_PART: begin
                push_ok = any_push;
                pop_ok  = any_pop;
            end
            FS_FULL: begin
                pop_ok  = any_pop;
                push_ok = any_push & any_pop;
            end
            default: begin
                push_ok = 1'b0;
                pop_ok  = 1'b0;
            end
        endcase
        if (flush) begin
            push_ok = 1'b0;
            pop_ok  = 1'b0;
        end
    end

    assign h_push_ok  = push_ok & h_push;
    assign e_push_ok  = push_ok & e_push & ~h_push;
    assign h_push_rej = h_push & ~push_ok & ~flush;
    assign e_push_rej = e_push & ~h_push & ~push_ok & ~flush;
    assign h_pop_ok   = pop_ok & h_pop;
    assign e_pop_ok   = pop_ok & e_pop & ~h_pop;
    assign h_pop_rej  = h_pop & ~pop_ok & ~flush;
    assign e_pop_rej  = e_pop & ~h_pop & ~pop_ok & ~flush;

    assign wbyte = h_push ? h_wdata : e_wdata;
    assign head  = mem[rd_ptr[AW-1:0]];

    // next occupancy and named transitions
    always_comb begin
        cnt_nxt   = flush ? '0 : cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        state_nxt = state;
        unique case (state)
            FS_EMPTY: if (push_ok) state_nxt = FS_PART;
            FS_PART: begin
                if (cnt_nxt == '0)           state_nxt = FS_EMPTY;
                else if (cnt_nxt == FULL_CNT) state_nxt = FS_FULL;
            end
            FS_FULL:  if (pop_ok && !push_ok) state_nxt = FS_PART;
            default:  state_nxt = FS_EMPTY;
        endcase
        if (flush) state_nxt = FS_EMPTY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= FS_EMPTY;
            cnt    <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            if (flush) begin
                rd_ptr <= wr_ptr;
            end else begin
                if (push_ok) wr_ptr <= wr_ptr + 1'b1;
                if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr[AW-1:0]] <= wbyte;
    end

endmodule

// File: rtl/tfifo_flags.sv
module tfifo_flags
    import tfifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [15:0]      cfg_wdata,
    input  logic             flush,
    input  logic             h_push_ok,
    input  logic             h_push_rej,
    input  logic             e_push_ok,
    input  logic             e_push_rej,
    input  logic             h_pop_ok,
    input  logic             h_pop_rej,
    input  logic             e_pop_ok,
    input  logic             e_pop_rej,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [15:0]      xfer_left,
    input  logic [3:0]       ack,
    output logic [15:0]      cfg_q,
    output flag_t            flg
);

    flag_t             nxt;
    logic [CNT_W-1:0]  rth;
    logic [15:0]       tth;
    logic              rx_above, tx_above;

    assign rth      = {1'b0, cfg_q[13:8]};
    assign tth      = {10'd0, cfg_q[5:0]};
    assign rx_above = cnt_nxt > rth;
    assign tx_above = xfer_left > tth;

    always_comb begin
        nxt = flg;
        // receive side
        if (flush) begin
            nxt.rx_ready = 1'b0;
            nxt.rx_drain = 1'b0;
        end else if (h_pop_ok) begin
            if (cnt_nxt == '0) begin
                nxt.rx_ready = 1'b0;
                nxt.rx_drain = 1'b0;
            end else if (!rx_above) begin
                nxt.rx_ready = 1'b0;
                nxt.rx_drain = 1'b1;
            end
        end else if (e_push_ok) begin
            nxt.rx_ready = rx_above;
            nxt.rx_drain = ~rx_above;
        end
        // host emptied the queue
        if (h_pop_ok && cnt_nxt == '0) nxt.acc_ready = 1'b1;
        else if (ack[0])               nxt.acc_ready = 1'b0;
        // host access error
        if (h_pop_rej || h_push_rej)                 nxt.acc_err = 1'b1;
        else if (h_pop_ok || h_push_ok || ack[1])    nxt.acc_err = 1'b0;
        // transmit underflow
        if (h_push_ok || h_push_rej) nxt.tx_udf = 1'b0;
        else if (e_pop_rej)          nxt.tx_udf = 1'b1;
        else if (ack[2])             nxt.tx_udf = 1'b0;
        // receive overrun
        if (h_pop_ok || h_pop_rej) nxt.rx_ovr = 1'b0;
        else if (e_push_rej)       nxt.rx_ovr = 1'b1;
        else if (ack[3])           nxt.rx_ovr = 1'b0;
        // transmit refill request
        if (h_push_ok || h_push_rej) begin
            nxt.tx_ready = 1'b0;
            nxt.tx_drain = 1'b0;
        end else if (e_pop_ok && cnt_nxt == '0 && xfer_left != 16'd0) begin
            nxt.tx_ready = tx_above;
            nxt.tx_drain = ~tx_above;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg   <= '0;
            cfg_q <= '0;
        end else begin
            flg <= nxt;
            if (cfg_we) cfg_q <= cfg_wdata & CFG_KEEP;
        end
    end

endmodule

// File: rtl/tfifo_stat.sv
module tfifo_stat
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic [PTR_W-1:0] occ,
    input  logic [5:0]       left,
    output logic [15:0]      word
);

    localparam logic [1:0] DCODE = depth_code(DEPTH);

    assign word = {DCODE, occ, 2'b00, left};

endmodule

// File: rtl/tfifo_thresh.sv
module tfifo_thresh
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_q,
    input  logic        host_push,
    input  logic [7:0]  host_wdata,
    input  logic        host_pop,
    output logic [7:0]  host_rdata,
    input  logic        eng_push,
    input  logic [7:0]  eng_wdata,
    input  logic        eng_pop,
    output logic [7:0]  eng_rdata,
    input  logic [15:0] xfer_left,
    input  logic [3:0]  flag_ack,
    output logic        rx_ready,
    output logic        rx_drain,
    output logic        tx_ready,
    output logic        tx_drain,
    output logic        acc_ready,
    output logic        acc_err,
    output logic        tx_udf,
    output logic        rx_ovr,
    output logic [15:0] buf_status
);

    logic             flush;
    logic             h_push_ok, h_push_rej, e_push_ok, e_push_rej;
    logic             h_pop_ok, h_pop_rej, e_pop_ok, e_pop_rej;
    logic [7:0]       head;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    fill_state_e      state;
    flag_t            flg;

    assign flush = cfg_we & (cfg_wdata[RX_CLR_BIT] | cfg_wdata[TX_CLR_BIT]);

    tfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .h_push(host_push), .h_wdata(host_wdata),
        .e_push(eng_push), .e_wdata(eng_wdata),
        .h_pop(host_pop), .e_pop(eng_pop),
        .h_push_ok(h_push_ok), .h_push_rej(h_push_rej),
        .e_push_ok(e_push_ok), .e_push_rej(e_push_rej),
        .h_pop_ok(h_pop_ok), .h_pop_rej(h_pop_rej),
        .e_pop_ok(e_pop_ok), .e_pop_rej(e_pop_rej),
        .head(head), .cnt(cnt), .cnt_nxt(cnt_nxt), .state(state)
    );

    tfifo_flags u_flags (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .flush(flush),
        .h_push_ok(h_push_ok), .h_push_rej(h_push_rej),
        .e_push_ok(e_push_ok), .e_push_rej(e_push_rej),
        .h_pop_ok(h_pop_ok), .h_pop_rej(h_pop_rej),
        .e_pop_ok(e_pop_ok), .e_pop_rej(e_pop_rej),
        .cnt_nxt(cnt_nxt), .xfer_left(xfer_left), .ack(flag_ack),
        .cfg_q(cfg_q), .flg(flg)
    );

    tfifo_stat #(.DEPTH(DEPTH)) u_stat (
        .occ(cnt[PTR_W-1:0]), .left(xfer_left[5:0]), .word(buf_status)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)         host_rdata <= 8'd0;
        else if (h_pop_ok)  host_rdata <= head;
        else if (h_pop_rej) host_rdata <= 8'd0;
    end

    assign eng_rdata = head;
    assign rx_ready  = flg.rx_ready;
    assign rx_drain  = flg.rx_drain;
    assign tx_ready  = flg.tx_ready;
    assign tx_drain  = flg.tx_drain;
    assign acc_ready = flg.acc_ready;
    assign acc_err   = flg.acc_err;
    assign tx_udf    = flg.tx_udf;
    assign rx_ovr    = flg.rx_ovr;

endmodule

// File: rtl/tfifo_thresh_chk.sv
module tfifo_thresh_chk
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             host_push,
    input logic             host_pop,
    input logic             eng_push,
    input logic             eng_pop,
    input logic [3:0]       flag_ack,
    input logic [CNT_W-1:0] cnt,
    input fill_state_e      state,
    input logic             acc_err,
    input logic             acc_ready,
    input logic             rx_ready,
    input logic             rx_drain,
    input logic             rx_ovr,
    input logic             tx_udf
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    a_r2_cnt_limit: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);

    a_r2_state_match: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == FS_EMPTY) == (cnt == '0)) && ((state == FS_FULL) == (cnt == FULL_CNT)));

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt + 1'b1 == $past(cnt)));

    a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0 && !rx_ready && !rx_drain));

    a_r6_pop_empty_err: assert property (@(posedge clk) disable iff (!rst_n)
        (host_pop && cnt == '0 && !flush) |=> acc_err);

    a_r7_push_full_err: assert property (@(posedge clk) disable iff (!rst_n)
        (host_push && cnt == FULL_CNT && !host_pop && !eng_pop && !flush) |=> (acc_err && cnt == FULL_CNT));

    a_r8_rx_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_ready && rx_drain));

    a_r9_last_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (host_pop && cnt == 1 && !host_push && !eng_push && !flush) |=> (acc_ready && !rx_ready && !rx_drain && cnt == '0));

    a_r10_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_push && !host_push && cnt == FULL_CNT && !host_pop && !eng_pop && !flush) |=> rx_ovr);

    a_r13_ack_udf: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ack[2] && !eng_pop) |=> !tx_udf);

endmodule

bind tfifo_thresh tfifo_thresh_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .host_push(host_push), .host_pop(host_pop),
    .eng_push(eng_push), .eng_pop(eng_pop), .flag_ack(flag_ack),
    .cnt(cnt), .state(state),
    .acc_err(acc_err), .acc_ready(acc_ready),
    .rx_ready(rx_ready), .rx_drain(rx_drain),
    .rx_ovr(rx_ovr), .tx_udf(tx_udf)
);

// File: tb/sim_tfifo_thresh.sv
module sim_tfifo_thresh;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_q;
    logic        host_push = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic        host_pop = 1'b0;
    logic [7:0]  host_rdata;
    logic        eng_push = 1'b0;
    logic [7:0]  eng_wdata = '0;
    logic        eng_pop = 1'b0;
    logic [7:0]  eng_rdata;
    logic [15:0] xfer_left = '0;
    logic [3:0]  flag_ack = '0;
    logic        rx_ready, rx_drain, tx_ready, tx_drain;
    logic        acc_ready, acc_err, tx_udf, rx_ovr;
    logic [15:0] buf_status;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tfifo_thresh #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
        .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop), .host_rdata(host_rdata),
        .eng_push(eng_push), .eng_wdata(eng_wdata), .eng_pop(eng_pop), .eng_rdata(eng_rdata),
        .xfer_left(xfer_left), .flag_ack(flag_ack),
        .rx_ready(rx_ready), .rx_drain(rx_drain), .tx_ready(tx_ready), .tx_drain(tx_drain),
        .acc_ready(acc_ready), .acc_err(acc_err), .tx_udf(tx_udf), .rx_ovr(rx_ovr),
        .buf_status(buf_status)
    );

    // other depths, idle, for the depth code
    for (genvar g = 0; g < 3; g++) begin : g_dep
        localparam int D = (g == 0) ? 8 : (g == 1) ? 32 : 64;
        logic [15:0] cq, st;
        logic [7:0]  hr, er;
        logic [7:0]  fl;
        tfifo_thresh #(.DEPTH(D)) ux (
            .clk(clk), .rst_n(rst_n), .cfg_we(1'b0), .cfg_wdata(16'd0), .cfg_q(cq),
            .host_push(1'b0), .host_wdata(8'd0), .host_pop(1'b0), .host_rdata(hr),
            .eng_push(1'b0), .eng_wdata(8'd0), .eng_pop(1'b0), .eng_rdata(er),
            .xfer_left(16'd0), .flag_ack(4'd0),
            .rx_ready(fl[0]), .rx_drain(fl[1]), .tx_ready(fl[2]), .tx_drain(fl[3]),
            .acc_ready(fl[4]), .acc_err(fl[5]), .tx_udf(fl[6]), .rx_ovr(fl[7]),
            .buf_status(st)
        );
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] occ();
        return buf_status[13:8];
    endfunction

    // one cycle of stimulus, called at a falling edge, returns at the next one
    task automatic op(input logic hp, input logic [7:0] hd, input logic hpop,
                      input logic ep, input logic [7:0] ed, input logic epop);
        host_push = hp; host_wdata = hd; host_pop = hpop;
        eng_push = ep; eng_wdata = ed; eng_pop = epop;
        @(negedge clk);
        host_push = 1'b0; host_pop = 1'b0; eng_push = 1'b0; eng_pop = 1'b0;
    endtask

    task automatic cfg_write(input logic [15:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ack_pulse(input logic [3:0] a);
        flag_ack = a;
        @(negedge clk);
        flag_ack = 4'd0;
    endtask

    task automatic t_reset();
        check("R1 occupancy", 16'(occ()), 16'd0);
        check("R1 flags", {8'd0, rx_ready, rx_drain, tx_ready, tx_drain, acc_ready, acc_err, tx_udf, rx_ovr}, 16'd0);
        check("R1 cfg_q", cfg_q, 16'd0);
        check("R1 host_rdata", 16'(host_rdata), 16'd0);
        check("R12 status depth16", buf_status, 16'h4000);
        check("R12 status depth8", g_dep[0].st, 16'h0000);
        check("R12 status depth32", g_dep[1].st, 16'h8000);
        check("R12 status depth64", g_dep[2].st, 16'hC000);
    endtask

    task automatic t_cfg();
        cfg_write(16'hFFFF);
        check("R4 mask", cfg_q, 16'hBFBF);
        cfg_write(16'h0302);
        check("R4 thresholds", cfg_q, 16'h0302);
    endtask

    task automatic t_fill_drain();
        for (int i = 0; i < DEPTH; i++) begin
            op(1'b0, 8'h00, 1'b0, 1'b1, 8'(8'hA0 + i), 1'b0);
            check("R2 occupancy fill", 16'(occ()), 16'(i + 1));
            check("R8 rx_ready", 16'(rx_ready), 16'((i + 1) > 3));
            check("R8 rx_drain", 16'(rx_drain), 16'((i + 1) <= 3));
        end
        op(1'b0, 8'h00, 1'b0, 1'b1, 8'hEE, 1'b0);
        check("R10 overrun set", 16'(rx_ovr), 16'd1);
        check("R10 occupancy held", 16'(occ()), 16'(DEPTH));
        op(1'b1, 8'hDD, 1'b0, 1'b0, 8'h00, 1'b0);
        check("R7 full push err", 16'(acc_err), 16'd1);
        check("R7 occupancy held", 16'(occ()), 16'(DEPTH));
        for (int i = 0; i < DEPTH; i++) begin
            int rem;
            rem = DEPTH - 1 - i;
            op(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
            check("R2 order", 16'(host_rdata), 16'(8'hA0 + i));
            check("R6 err cleared", 16'(acc_err), 16'd0);
            check("R6 ovr cleared", 16'(rx_ovr), 16'd0);
            check("R9 rx_ready", 16'(rx_ready), 16'(rem > 3));
            check("R9 rx_drain", 16'(rx_drain), 16'(rem >= 1 && rem <= 3));
            check("R9 acc_ready", 16'(acc_ready), 16'(rem == 0));
        end
        op(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R6 empty pop data", 16'(host_rdata), 16'd0);
        check("R6 empty pop err", 16'(acc_err), 16'd1);
        check("R6 occupancy", 16'(occ()), 16'd0);
        ack_pulse(4'b0011);
        check("R13 ack acc_ready", 16'(acc_ready), 16'd0);
        check("R13 ack acc_err", 16'(acc_err), 16'd0);
    endtask

    task automatic t_simul();
        op(1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 1'b0);
        op(1'b1, 8'h22, 1'b0, 1'b0, 8'h00, 1'b0);
        op(1'b1, 8'h33, 1'b0, 1'b0, 8'h00, 1'b0);
        check("R2 host fill", 16'(occ()), 16'd3);
        op(1'b0, 8'h00, 1'b1, 1'b1, 8'h44, 1'b0);
        check("R2 push+pop occupancy", 16'(occ()), 16'd3);
        check("R2 push+pop data", 16'(host_rdata), 16'h11);
        check("R9 drain at threshold", 16'(rx_drain), 16'd1);
        op(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R2 order 2", 16'(host_rdata), 16'h22);
        op(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R2 order 3", 16'(host_rdata), 16'h33);
        op(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R2 engine byte", 16'(host_rdata), 16'h44);
        check("R9 acc_ready", 16'(acc_ready), 16'd1);
    endtask

    task automatic t_priority();
        op(1'b1, 8'h55, 1'b0, 1'b1, 8'h66, 1'b0);
        check("R3 one push kept", 16'(occ()), 16'd1);
        op(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R3 host byte wins", 16'(host_rdata), 16'h55);
        op(1'b1, 8'h77, 1'b0, 1'b0, 8'h00, 1'b0);
        op(1'b1, 8'h88, 1'b0, 1'b0, 8'h00, 1'b0);
        op(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1);
        check("R3 one pop taken", 16'(occ()), 16'd1);
        check("R3 host pop wins", 16'(host_rdata), 16'h77);
        check("R3 head next", 16'(eng_rdata), 16'h88);
        op(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1);
        check("R2 engine pop", 16'(occ()), 16'd0);
    endtask

    task automatic t_tx();
        op(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1);
        check("R11 underflow set", 16'(tx_udf), 16'd1);
        ack_pulse(4'b0100);
        check("R13 ack underflow", 16'(tx_udf), 16'd0);
        op(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1);
        op(1'b1, 8'h01, 1'b0, 1'b0, 8'h00, 1'b0);
        check("R7 push clears underflow", 16'(tx_udf), 16'd0);
        xfer_left = 16'd3;
        op(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1);
        check("R11 tx_ready above", 16'(tx_ready), 16'd1);
        check("R11 tx_drain above", 16'(tx_drain), 16'd0);
        op(1'b1, 8'h02, 1'b0, 1'b0, 8'h00, 1'b0);
        check("R7 push clears tx flags", {14'd0, tx_ready, tx_drain}, 16'd0);
        xfer_left = 16'd2;
        op(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1);
        check("R11 tx_drain at threshold", {14'd0, tx_ready, tx_drain}, 16'd1);
        op(1'b1, 8'h03, 1'b0, 1'b0, 8'h00, 1'b0);
        xfer_left = 16'h0045;
        #1;
        check("R12 status packing", buf_status, 16'h4105);
        op(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1);
        xfer_left = 16'd0;
    endtask

    task automatic t_clear();
        for (int i = 0; i < 4; i++) op(1'b0, 8'h00, 1'b0, 1'b1, 8'(8'hB0 + i), 1'b0);
        check("R8 ready before clear", 16'(rx_ready), 16'd1);
        host_push = 1'b1; host_wdata = 8'h99;
        cfg_write(16'h0342);
        host_push = 1'b0;
        check("R5 emptied", 16'(occ()), 16'd0);
        check("R5 rx flags", {14'd0, rx_ready, rx_drain}, 16'd0);
        check("R4 clear bit not stored", cfg_q, 16'h0302);
        op(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R5 push ignored", 16'(acc_err), 16'd1);
        check("R5 pop data", 16'(host_rdata), 16'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_fill_drain();
        t_simul();
        t_priority();
        t_tx();
        t_clear();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule